// File: doc/BRIEF.md
# Peripheral Pin Remap Register File with Shadow Monitor

This block stores the configuration that routes peripheral functions to device pins. It has seventeen 5-bit select registers. Nine are input selects and eight are output selects. A simple request/acknowledge write port updates them. The port honours an external lock flag: a locked write is acknowledged as usual but leaves every register untouched.

Every select register has a shadow copy. A legitimate write loads the primary and the shadow on the same clock edge. A monitor compares all pairs on every cycle. Any difference, which can only come from a disturbance of a primary register, trips a sticky configuration-mismatch reset request. The request stays high until the system reset clears the block.

Each output select is also decoded into a 3-bit source index for its pin. A fault-injection port flips one bit of a chosen primary register so that the monitor path can be exercised.

The write controller has two states, WR_IDLE and WR_ACK:
- WR_IDLE moves to WR_ACK on any request. This happens whether or not the request commits.
- WR_ACK always returns to WR_IDLE one cycle later.

The monitor also has two states, MON_WATCH and MON_TRIPPED:
- MON_WATCH moves to MON_TRIPPED when any pair differs.
- MON_TRIPPED is left only through reset.

Top module: `pinmap_remap_regs`

## Requirements
- R1: After reset, all 17 select registers read zero, `out_src` is all zero, `wr_ack` is low and `mismatch_rst_req` is low.
- R2: A request accepted in WR_IDLE with `lock` low and a valid address stores `wr_data` into that register alone, visible after the accepting edge.
- R3: Every request seen in WR_IDLE raises `wr_ack` for exactly the next cycle. A request present while `wr_ack` is high is ignored.
- R4: A request made while `lock` is high is acknowledged but changes no register.
- R5: A request to an address of 17 or above is acknowledged but changes no register.
- R6: Addresses 0 to 8 select input register k, shown at `in_sel[5k+4:5k]`. Addresses 9 to 16 select output register k = address-9, shown at `out_sel[5k+4:5k]`.
- R7: Output code decode into `out_src[3k+2:3k]`. Each code maps to a source index as follows:
  - code 3 (UART transmit) gives 1
  - code 4 (UART ready-to-send) gives 2
  - code 7 (SPI data out) gives 3
  - code 8 (SPI clock out) gives 4
  - code 9 (SPI slave select out) gives 5
  - code 18 (compare channel 1) gives 6
  - code 19 (compare channel 2) gives 7
- R8: Code 0 and every code not listed in R7 decode to 0, the pin's default port function.
- R9: A fault injection on `fi_addr`/`fi_bit` inverts that bit of the primary register only. `mismatch_rst_req` is still low after the flipping edge and is high after the next edge.
- R10: Once high, `mismatch_rst_req` stays high until reset, even after the disturbed register is rewritten.
- R11: Legitimate writes alone never raise `mismatch_rst_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock | input | 1 | Write lock flag; high blocks commits |
| wr_req | input | 1 | Write request |
| wr_addr | input | 5 | Register address (0-8 input, 9-16 output) |
| wr_data | input | 5 | Select value to write |
| wr_ack | output | 1 | One-cycle acknowledge |
| fi_en | input | 1 | Fault injection strobe |
| fi_addr | input | 5 | Register to disturb |
| fi_bit | input | 3 | Bit to invert |
| in_sel | output | 45 | Nine input select fields |
| out_sel | output | 40 | Eight output select fields |
| out_src | output | 24 | Decoded source index per output pin |
| mismatch_rst_req | output | 1 | Sticky configuration-mismatch reset request |

## Verification
The bench writes with the lock set, to out-of-range addresses, and with a request held into the acknowledge cycle. A design that ignored the lock, wrapped bad addresses, or took a second commit would then change a register it must not. It sweeps all 32 output codes, which catches a decoder that mislabels a source or lets an unlisted code through. It injects faults in both register banks and checks the request on each side of the detection edge. A monitor that lagged, cleared itself on repair, or compared the shadow against itself would show the wrong level there.

// File: rtl/pinmap_pkg.sv
package pinmap_pkg;

    localparam int SRC_W = 3;

    typedef enum logic [SRC_W-1:0] {
        SRC_PORT     = 3'd0,
        SRC_UART_TX  = 3'd1,
        SRC_UART_RTS = 3'd2,
        SRC_SPI_DO   = 3'd3,
        SRC_SPI_CLK  = 3'd4,
        SRC_SPI_SS   = 3'd5,
        SRC_CMP1     = 3'd6,
        SRC_CMP2     = 3'd7
    } src_e;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_ACK  = 1'b1
    } wr_state_e;

    typedef enum logic {
        MON_WATCH   = 1'b0,
        MON_TRIPPED = 1'b1
    } mon_state_e;

    function automatic src_e decode_out(input logic [4:0] code);
        src_e s;
        unique case (code)
            5'd3:    s = SRC_UART_TX;
            5'd4:    s = SRC_UART_RTS;
            5'd7:    s = SRC_SPI_DO;
            5'd8:    s = SRC_SPI_CLK;
            5'd9:    s = SRC_SPI_SS;
            5'd18:   s = SRC_CMP1;
            5'd19:   s = SRC_CMP2;
            default: s = SRC_PORT;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pinmap_wr_ctrl.sv
module pinmap_wr_ctrl
    import pinmap_pkg::*;
#(
    parameter int N_REG  = 17,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              commit,
    output logic              wr_ack
);

    wr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (wr_req) state_d = WR_ACK;
            WR_ACK:  state_d = WR_IDLE;
            default: state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        commit = (state_q == WR_IDLE) && wr_req && !lock
                 && (int'(wr_addr) < N_REG);
        wr_ack = (state_q == WR_ACK);
    end

endmodule

// File: rtl/pinmap_regfile.sv
module pinmap_regfile #(
    parameter int N_REG  = 17,
    parameter int SEL_W  = 5,
    parameter int ADDR_W = 5,
    parameter int BIT_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [SEL_W-1:0]       wr_data,
    input  logic                   fi_en,
    input  logic [ADDR_W-1:0]      fi_addr,
    input  logic [BIT_W-1:0]       fi_bit,
    output logic [N_REG*SEL_W-1:0] prim_flat,
    output logic [N_REG-1:0]       mismatch
);

    for (genvar g = 0; g < N_REG; g++) begin : g_reg
        logic [SEL_W-1:0] prim_q, shad_q, flip_m;
        logic             hit, fhit;

        assign hit    = commit && (wr_addr == ADDR_W'(g));
        assign fhit   = fi_en && (fi_addr == ADDR_W'(g));
        assign flip_m = fhit ? (SEL_W'(1) << fi_bit) : '0;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prim_q <= '0;
                shad_q <= '0;
            end else begin
                prim_q <= (hit ? wr_data : prim_q) ^ flip_m;
                if (hit) shad_q <= wr_data;
            end
        end

        assign prim_flat[g*SEL_W +: SEL_W] = prim_q;
        assign mismatch[g] = (prim_q != shad_q);
    end

endmodule

// File: rtl/pinmap_shadow_mon.sv
module pinmap_shadow_mon
    import pinmap_pkg::*;
#(
    parameter int N_REG = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REG-1:0] mismatch,
    output logic             rst_req
);

    mon_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MON_WATCH:   if (|mismatch) state_d = MON_TRIPPED;
            MON_TRIPPED: state_d = MON_TRIPPED;
            default:     state_d = MON_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MON_WATCH;
        else        state_q <= state_d;
    end

    always_comb begin
        rst_req = (state_q == MON_TRIPPED);
    end

endmodule

// File: rtl/pinmap_out_decode.sv
module pinmap_out_decode
    import pinmap_pkg::*;
#(
    parameter int N_OUT = 8,
    parameter int SEL_W = 5
) (
    input  logic [N_OUT*SEL_W-1:0] out_sel,
    output logic [N_OUT*SRC_W-1:0] out_src
);

    for (genvar p = 0; p < N_OUT; p++) begin : g_pin
        logic [4:0] code;
        assign code = 5'(out_sel[p*SEL_W +: SEL_W]);
        assign out_src[p*SRC_W +: SRC_W] = decode_out(code);
    end

endmodule

// File: rtl/pinmap_remap_regs.sv
module pinmap_remap_regs
    import pinmap_pkg::*;
#(
    parameter int N_IN   = 9,
    parameter int N_OUT  = 8,
    parameter int SEL_W  = 5,
    parameter int N_REG  = N_IN + N_OUT,
    parameter int ADDR_W = $clog2(N_REG),
    parameter int BIT_W  = $clog2(SEL_W)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lock,
    input  logic                   wr_req,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [SEL_W-1:0]       wr_data,
    output logic                   wr_ack,
    input  logic                   fi_en,
    input  logic [ADDR_W-1:0]      fi_addr,
    input  logic [BIT_W-1:0]       fi_bit,
    output logic [N_IN*SEL_W-1:0]  in_sel,
    output logic [N_OUT*SEL_W-1:0] out_sel,
    output logic [N_OUT*SRC_W-1:0] out_src,
    output logic                   mismatch_rst_req
);

    logic                   commit;
    logic [N_REG*SEL_W-1:0] prim_flat;
    logic [N_REG-1:0]       mismatch;

    pinmap_wr_ctrl #(.N_REG(N_REG), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .lock(lock), .wr_req(wr_req),
        .wr_addr(wr_addr), .commit(commit), .wr_ack(wr_ack)
    );

    pinmap_regfile #(.N_REG(N_REG), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .BIT_W(BIT_W)) u_rf (
        .clk(clk), .rst_n(rst_n), .commit(commit), .wr_addr(wr_addr),
        .wr_data(wr_data), .fi_en(fi_en), .fi_addr(fi_addr), .fi_bit(fi_bit),
        .prim_flat(prim_flat), .mismatch(mismatch)
    );

    pinmap_shadow_mon #(.N_REG(N_REG)) u_mon (
        .clk(clk), .rst_n(rst_n), .mismatch(mismatch), .rst_req(mismatch_rst_req)
    );

    assign in_sel  = prim_flat[N_IN*SEL_W-1:0];
    assign out_sel = prim_flat[N_REG*SEL_W-1:N_IN*SEL_W];

    pinmap_out_decode #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_dec (
        .out_sel(out_sel), .out_src(out_src)
    );

endmodule

// File: rtl/pinmap_remap_regs_chk.sv
module pinmap_remap_regs_chk #(
    parameter int N_REG  = 17,
    parameter int ADDR_W = 5,
    parameter int IN_W   = 45,
    parameter int OUT_W  = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lock,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_ack,
    input logic              fi_en,
    input logic [IN_W-1:0]   in_sel,
    input logic [OUT_W-1:0]  out_sel,
    input logic [N_REG-1:0]  mismatch,
    input logic              rst_req
);

    p_req_acked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> wr_ack);

    p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);

    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && lock && !fi_en) |=> ($stable(in_sel) && $stable(out_sel)));

    p_bad_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && (int'(wr_addr) >= N_REG) && !fi_en)
        |=> ($stable(in_sel) && $stable(out_sel)));

    p_detect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|mismatch) |=> rst_req);

    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req && !(|mismatch)) |=> !rst_req);

endmodule

bind pinmap_remap_regs pinmap_remap_regs_chk #(
    .N_REG(N_REG), .ADDR_W(ADDR_W), .IN_W(N_IN*SEL_W), .OUT_W(N_OUT*SEL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lock(lock), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_ack(wr_ack), .fi_en(fi_en), .in_sel(in_sel), .out_sel(out_sel),
    .mismatch(mismatch), .rst_req(mismatch_rst_req)
);

// File: tb/pinmap_remap_regs_test.sv
module pinmap_remap_regs_test;

    localparam int N_IN = 9, N_OUT = 8, N_REG = 17;

    logic        clk = 1'b0, rst_n = 1'b0, lock = 1'b0, wr_req = 1'b0, fi_en = 1'b0;
    logic [4:0]  wr_addr = '0, wr_data = '0, fi_addr = '0;
    logic [2:0]  fi_bit = '0;
    logic        wr_ack, mismatch_rst_req;
    logic [44:0] in_sel;
    logic [39:0] out_sel;
    logic [23:0] out_src;

    int checks = 0, errors = 0;
    logic [4:0] model [N_REG];

    always #10 clk = ~clk;

    pinmap_remap_regs uut (
        .clk(clk), .rst_n(rst_n), .lock(lock), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .fi_en(fi_en), .fi_addr(fi_addr),
        .fi_bit(fi_bit), .in_sel(in_sel), .out_sel(out_sel), .out_src(out_src),
        .mismatch_rst_req(mismatch_rst_req)
    );

    function automatic logic [2:0] exp_src(input logic [4:0] c);
        case (c)
            5'd3: return 3'd1;   5'd4: return 3'd2;   5'd7: return 3'd3;
            5'd8: return 3'd4;   5'd9: return 3'd5;   5'd18: return 3'd6;
            5'd19: return 3'd7;  default: return 3'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        logic [44:0] ei;
        logic [39:0] eo;
        logic [23:0] es;
        for (int k = 0; k < N_IN; k++) ei[k*5 +: 5] = model[k];
        for (int k = 0; k < N_OUT; k++) begin
            eo[k*5 +: 5] = model[N_IN+k];
            es[k*3 +: 3] = exp_src(model[N_IN+k]);
        end
        check({req, " in_sel"}, 64'(in_sel), 64'(ei));
        check({req, " out_sel"}, 64'(out_sel), 64'(eo));
        check({req, " out_src"}, 64'(out_src), 64'(es));
    endtask

    // one-cycle request; checks the acknowledge window (R3)
    task automatic do_write(input logic [4:0] a, input logic [4:0] d, input logic lk);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d; lock = lk;
        @(negedge clk);
        wr_req = 1'b0; lock = 1'b0;
        check("R3 ack high", 64'(wr_ack), 64'd1);
        @(negedge clk);
        check("R3 ack low", 64'(wr_ack), 64'd0);
        if (!lk && a < N_REG) model[a] = d;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < N_REG; k++) model[k] = '0;
    endtask

    task automatic t_reset();
        apply_reset();
        check_regs("R1");
        check("R1 ack", 64'(wr_ack), 64'd0);
        check("R1 rst_req", 64'(mismatch_rst_req), 64'd0);
    endtask

    task automatic t_writes();
        do_write(5'd0, 5'd21, 1'b0);
        do_write(5'd8, 5'd7, 1'b0);
        do_write(5'd9, 5'd3, 1'b0);
        do_write(5'd16, 5'd19, 1'b0);
        do_write(5'd4, 5'd31, 1'b0);
        check_regs("R2 R6");
    endtask

    task automatic t_locked();
        do_write(5'd0, 5'd1, 1'b1);
        do_write(5'd12, 5'd8, 1'b1);
        check_regs("R4");
    endtask

    task automatic t_bad_addr();
        do_write(5'd17, 5'd9, 1'b0);
        do_write(5'd31, 5'd4, 1'b0);
        check_regs("R5");
    endtask

    task automatic t_held_request();
        @(negedge clk);
        wr_req = 1'b1; wr_addr = 5'd2; wr_data = 5'd11;
        @(negedge clk);
        check("R3 ack on held", 64'(wr_ack), 64'd1);
        wr_data = 5'd22;
        @(negedge clk);
        wr_req = 1'b0;
        check("R3 ack drops", 64'(wr_ack), 64'd0);
        model[2] = 5'd11;
        check_regs("R3 held ignored");
    endtask

    task automatic t_decode();
        for (int c = 0; c < 32; c++) begin
            do_write(5'd12, 5'(c), 1'b0);
            check(((c == 3) || (c == 4) || (c == 7) || (c == 8) || (c == 9) || (c == 18) || (c == 19))
                  ? "R7 decode" : "R8 fallback", 64'(out_src[9 +: 3]), 64'(exp_src(5'(c))));
        end
        check("R11 no spurious", 64'(mismatch_rst_req), 64'd0);
    endtask

    task automatic t_fault(input logic [4:0] a, input logic [2:0] b);
        @(negedge clk);
        fi_en = 1'b1; fi_addr = a; fi_bit = b;
        @(negedge clk);
        fi_en = 1'b0;
        model[a] = model[a] ^ (5'd1 << b);
        check("R9 before detect", 64'(mismatch_rst_req), 64'd0);
        check_regs("R9 primary flipped");
        @(negedge clk);
        check("R9 detected", 64'(mismatch_rst_req), 64'd1);
    endtask

    task automatic t_sticky(input logic [4:0] a);
        do_write(a, 5'd0, 1'b0);
        repeat (3) @(negedge clk);
        check("R10 sticky", 64'(mismatch_rst_req), 64'd1);
    endtask

    initial begin
        for (int k = 0; k < N_REG; k++) model[k] = '0;
        t_reset();
        t_writes();
        t_locked();
        t_bad_addr();
        t_held_request();
        t_decode();
        t_fault(5'd10, 3'd2);
        t_sticky(5'd10);
        t_reset();
        do_write(5'd4, 5'd6, 1'b0);
        t_fault(5'd4, 3'd4);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule